// File: doc/BRIEF.md
# Dual-Issue Pair Checker

This block sits in the issue stage of a statically scheduled two-way processor. Every cycle the fetch unit presents one 64-bit word that carries two 32-bit instructions. The upper half is the integer slot, which holds integer operations, loads and stores. The lower half is the floating-point slot, which holds FP arithmetic. The block decides in the same cycle whether to issue both instructions, only the integer-slot one, or neither. It then tells fetch whether to hold the word for another cycle.

The decision reads the class field and the three register fields of each instruction, so six register specifiers in all. It applies four checks:
- Each instruction must have a class that is legal in its slot.
- The FP-slot instruction may issue only once the integer-slot instruction of the same pair has issued.
- The FP-slot instruction may not read the FP register that a load in the integer slot writes in the same cycle.
- No instruction may read a register that an earlier load is still filling.

A scoreboard keeps, for each integer and each FP register, a small countdown of the load-delay cycles still open. When only the integer-slot instruction issues, the FP-slot instruction stays and is the only candidate in later cycles. An instruction whose class does not belong in its slot is dropped and reported on a squash output. Everything behind it in slot order is dropped with it, so only the legal prefix of a pair can issue.

Top module: `dual_issue_checker`

## Requirements
- R1: An instruction word has its class in bits [31:28]. Its destination, first-source and second-source fields sit at bits 23, 18 and 13, each REG_BITS wide. The integer slot is pairWord[63:32] and the FP slot is pairWord[31:0]. The classes are:
  - 0: no-op, legal in both slots.
  - 1: integer ALU, reads two integer registers and writes one.
  - 2: integer load, reads an integer base and writes an integer register.
  - 3: FP load, reads an integer base and writes an FP register.
  - 4: FP store, reads an integer base and an FP register in the second-source field.
  - 5: FP ALU, reads two FP registers and writes one.
  - Classes 1 to 4 are legal only in the integer slot. Class 5 is legal only in the FP slot. Classes 6 to 15 are legal in neither.
- R2: When both instructions are legal and unblocked, issueLeft and issueRight rise together in the same cycle, with holdFetch low. This includes an FP load paired with an independent FP operation.
- R3: issueRight is never high unless issueLeft is high in the same cycle, or the integer-slot instruction of the same pair issued in an earlier cycle.
- R4: An FP load in the integer slot may be paired with an FP ALU operation that reads the load's destination register. In that case only the integer-slot instruction issues that cycle and holdFetch is high.
- R5: An integer-slot instruction with a class illegal in that slot issues nothing. squashSlot is raised and the pair is dropped. If the integer slot issues but the FP-slot class is illegal there, squashSlot is raised together with issueLeft and the pair is dropped.
- R6: A load that issues marks its destination register, in its own register file, busy for the LOAD_DELAY cycles that follow. Any instruction whose source is busy in the matching file does not issue.
- R7: After an integer-slot-only issue, later cycles of the same pair evaluate only the FP-slot instruction. It issues on issueRight alone once its sources are free, and the integer-slot instruction never issues twice.
- R8: holdFetch is high exactly when pairValid is high and the pair has not been completed by an issue or squash of its last remaining instruction in that cycle.
- R9: With pairValid low, no issue, hold or squash output is high, and the scoreboard keeps counting down.
- R10: While rstN is low all outputs are low. After reset no register is busy and no pair is half issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| pairValid | input | 1 | Fetch presents a valid instruction pair |
| pairWord | input | 64 | Instruction pair, integer slot in the upper half |
| issueLeft | output | 1 | The integer-slot instruction issues this cycle |
| issueRight | output | 1 | The FP-slot instruction issues this cycle |
| holdFetch | output | 1 | Fetch must present the same pair again next cycle |
| squashSlot | output | 1 | A wrong-class instruction was dropped this cycle |

## Verification
The bench builds the block with NUM_REGS set to 8, so register fields that the bench derives arithmetically from the two class codes collide often, and with LOAD_DELAY set to 2, so a load shadow spans two pairs and a held FP-slot instruction waits several cycles. Under that setting every pairing of the sixteen class codes in each slot is swept, with idle cycles in between. This reaches the following:
- every legality combination;
- the in-pair FP load hazard;
- scoreboard blocks carried over from earlier pairs;
- the multi-cycle held-right path.

Directed pairs before the sweep cover reset during an open load shadow.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

  // Instruction field positions.
  localparam int CLS_LSB  = 28;
  localparam int DST_LSB  = 23;
  localparam int SRC1_LSB = 18;
  localparam int SRC2_LSB = 13;

  // Class codes.
  localparam logic [3:0] CLS_NOP      = 4'd0;
  localparam logic [3:0] CLS_INT_ALU  = 4'd1;
  localparam logic [3:0] CLS_INT_LOAD = 4'd2;
  localparam logic [3:0] CLS_FP_LOAD  = 4'd3;
  localparam logic [3:0] CLS_FP_STORE = 4'd4;
  localparam logic [3:0] CLS_FP_ALU   = 4'd5;

  typedef struct packed {
    logic legalLeft;
    logic legalRight;
    logic rdInt1;
    logic rdInt2;
    logic rdFp1;
    logic rdFp2;
    logic wrInt;
    logic wrFp;
    logic isLoad;
  } slotInfo_t;

  // Datapath -> control summary.
  typedef struct packed {
    logic leftLegal;
    logic rightLegal;
    logic leftBlocked;
    logic rightBlocked;
    logic intraHit;
    logic leftLoadInt;
    logic leftLoadFp;
  } hazard_t;

  // Control -> datapath strobes.
  typedef struct packed {
    logic markInt;
    logic markFp;
  } sbStrobe_t;

  function automatic slotInfo_t classify(input logic [3:0] cls);
    slotInfo_t s;
    s = '0;
    case (cls)
      CLS_NOP: begin
        s.legalLeft  = 1'b1;
        s.legalRight = 1'b1;
      end
      CLS_INT_ALU: begin
        s.legalLeft = 1'b1;
        s.rdInt1    = 1'b1;
        s.rdInt2    = 1'b1;
        s.wrInt     = 1'b1;
      end
      CLS_INT_LOAD: begin
        s.legalLeft = 1'b1;
        s.rdInt1    = 1'b1;
        s.wrInt     = 1'b1;
        s.isLoad    = 1'b1;
      end
      CLS_FP_LOAD: begin
        s.legalLeft = 1'b1;
        s.rdInt1    = 1'b1;
        s.wrFp      = 1'b1;
        s.isLoad    = 1'b1;
      end
      CLS_FP_STORE: begin
        s.legalLeft = 1'b1;
        s.rdInt1    = 1'b1;
        s.rdFp2     = 1'b1;
      end
      CLS_FP_ALU: begin
        s.legalRight = 1'b1;
        s.rdFp1      = 1'b1;
        s.rdFp2      = 1'b1;
        s.wrFp       = 1'b1;
      end
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/slot_decode.sv
module slot_decode
  import dual_issue_pkg::*;
#(
  parameter int REG_BITS = 5
) (
  input  logic [31:0]         instr,
  output slotInfo_t           info,
  output logic [REG_BITS-1:0] dstReg,
  output logic [REG_BITS-1:0] src1Reg,
  output logic [REG_BITS-1:0] src2Reg
);

  logic unusedBits;

  assign info       = classify(instr[CLS_LSB +: 4]);
  assign dstReg     = instr[DST_LSB +: REG_BITS];
  assign src1Reg    = instr[SRC1_LSB +: REG_BITS];
  assign src2Reg    = instr[SRC2_LSB +: REG_BITS];
  assign unusedBits = ^instr;

endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard #(
  parameter int NUM_REGS   = 32,
  parameter int LOAD_DELAY = 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        mark,
  input  logic [$clog2(NUM_REGS)-1:0] markIdx,
  output logic [NUM_REGS-1:0]         busy
);

  localparam int CNT_BITS = $clog2(LOAD_DELAY + 1);
  localparam logic [CNT_BITS-1:0] RELOAD = CNT_BITS'(LOAD_DELAY);

  genvar r;
  generate
    for (r = 0; r < NUM_REGS; r++) begin : g_reg
      logic [CNT_BITS-1:0] remain;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          remain <= '0;
        end else if (mark && (markIdx == r)) begin
          remain <= RELOAD;
        end else if (remain != '0) begin
          remain <= remain - 1'b1;
        end
      end

      assign busy[r] = (remain != '0);
    end
  endgenerate

endmodule

// File: rtl/issue_datapath.sv
module issue_datapath
  import dual_issue_pkg::*;
#(
  parameter int NUM_REGS   = 32,
  parameter int LOAD_DELAY = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [63:0] pairWord,
  input  sbStrobe_t   strobe,
  output hazard_t     haz
);

  localparam int REG_BITS = $clog2(NUM_REGS);
  localparam int LEFT     = 1;
  localparam int RIGHT    = 0;

  slotInfo_t           info    [2];
  logic [REG_BITS-1:0] dstReg  [2];
  logic [REG_BITS-1:0] src1Reg [2];
  logic [REG_BITS-1:0] src2Reg [2];
  logic [1:0]          blocked;
  logic [NUM_REGS-1:0] busy    [2];   // 0: integer file, 1: FP file
  logic                intraHit;

  genvar s;
  generate
    for (s = 0; s < 2; s++) begin : g_slot
      slot_decode #(.REG_BITS(REG_BITS)) u_dec (
        .instr  (pairWord[32*s +: 32]),
        .info   (info[s]),
        .dstReg (dstReg[s]),
        .src1Reg(src1Reg[s]),
        .src2Reg(src2Reg[s])
      );

      assign blocked[s] = (info[s].rdInt1 & busy[0][src1Reg[s]])
                        | (info[s].rdInt2 & busy[0][src2Reg[s]])
                        | (info[s].rdFp1  & busy[1][src1Reg[s]])
                        | (info[s].rdFp2  & busy[1][src2Reg[s]]);
    end
  endgenerate

  genvar f;
  generate
    for (f = 0; f < 2; f++) begin : g_file
      reg_scoreboard #(
        .NUM_REGS  (NUM_REGS),
        .LOAD_DELAY(LOAD_DELAY)
      ) u_sb (
        .clk    (clk),
        .rstN   (rstN),
        .mark   ((f == 0) ? strobe.markInt : strobe.markFp),
        .markIdx(dstReg[LEFT]),
        .busy   (busy[f])
      );
    end
  endgenerate

  always_comb begin
    intraHit = info[LEFT].isLoad & info[LEFT].wrFp &
               ((info[RIGHT].rdFp1 & (src1Reg[RIGHT] == dstReg[LEFT])) |
                (info[RIGHT].rdFp2 & (src2Reg[RIGHT] == dstReg[LEFT])));
  end

  assign haz.leftLegal    = info[LEFT].legalLeft;
  assign haz.rightLegal   = info[RIGHT].legalRight;
  assign haz.leftBlocked  = blocked[LEFT];
  assign haz.rightBlocked = blocked[RIGHT];
  assign haz.intraHit     = intraHit;
  assign haz.leftLoadInt  = info[LEFT].isLoad & info[LEFT].wrInt;
  assign haz.leftLoadFp   = info[LEFT].isLoad & info[LEFT].wrFp;

endmodule

// File: rtl/issue_control.sv
module issue_control
  import dual_issue_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pairValid,
  input  hazard_t   haz,
  output sbStrobe_t strobe,
  output logic      issueLeft,
  output logic      issueRight,
  output logic      holdFetch,
  output logic      squashSlot
);

  logic leftDone;
  logic leftLive;
  logic leftSquash;
  logic rightEval;
  logic rightSquash;
  logic retire;

  always_comb begin
    leftLive    = rstN & pairValid & ~leftDone;
    issueLeft   = leftLive & haz.leftLegal & ~haz.leftBlocked;
    leftSquash  = leftLive & ~haz.leftLegal;
    rightEval   = rstN & pairValid & (issueLeft | leftDone);
    rightSquash = rightEval & ~haz.rightLegal;
    issueRight  = rightEval & haz.rightLegal & ~haz.rightBlocked &
                  ~(issueLeft & haz.intraHit);
    retire      = leftSquash | rightSquash | issueRight;
    holdFetch   = rstN & pairValid & ~retire;
    squashSlot  = leftSquash | rightSquash;
  end

  assign strobe.markInt = issueLeft & haz.leftLoadInt;
  assign strobe.markFp  = issueLeft & haz.leftLoadFp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftDone <= 1'b0;
    end else if (retire) begin
      leftDone <= 1'b0;
    end else if (issueLeft) begin
      leftDone <= 1'b1;
    end
  end

endmodule

// File: rtl/dual_issue_checker.sv
module dual_issue_checker
  import dual_issue_pkg::*;
#(
  parameter int NUM_REGS   = 32,
  parameter int LOAD_DELAY = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pairValid,
  input  logic [63:0] pairWord,
  output logic        issueLeft,
  output logic        issueRight,
  output logic        holdFetch,
  output logic        squashSlot
);

  hazard_t   haz;
  sbStrobe_t strobe;

  issue_datapath #(
    .NUM_REGS  (NUM_REGS),
    .LOAD_DELAY(LOAD_DELAY)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pairWord(pairWord),
    .strobe  (strobe),
    .haz     (haz)
  );

  issue_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .pairValid (pairValid),
    .haz       (haz),
    .strobe    (strobe),
    .issueLeft (issueLeft),
    .issueRight(issueRight),
    .holdFetch (holdFetch),
    .squashSlot(squashSlot)
  );

endmodule

// File: rtl/dual_issue_sva.sv
module dual_issue_sva
  import dual_issue_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input logic        clk,
  input logic        rstN,
  input logic        pairValid,
  input logic [63:0] pairWord,
  input logic        issueLeft,
  input logic        issueRight,
  input logic        holdFetch,
  input logic        squashSlot
);

  localparam int RB = $clog2(NUM_REGS);

  logic [31:0]   lw;
  logic [31:0]   rw;
  slotInfo_t     li;
  slotInfo_t     ri;
  logic [RB-1:0] lDst;
  logic [RB-1:0] lSrc1;
  logic [RB-1:0] rSrc1;
  logic [RB-1:0] rSrc2;
  logic          pendRight;

  assign lw    = pairWord[63:32];
  assign rw    = pairWord[31:0];
  assign li    = classify(lw[CLS_LSB +: 4]);
  assign ri    = classify(rw[CLS_LSB +: 4]);
  assign lDst  = lw[DST_LSB +: RB];
  assign lSrc1 = lw[SRC1_LSB +: RB];
  assign rSrc1 = rw[SRC1_LSB +: RB];
  assign rSrc2 = rw[SRC2_LSB +: RB];

  // Watches for a pair whose integer slot went out while its FP slot stayed.
  always_ff @(posedge clk) begin
    if (!rstN)                        pendRight <= 1'b0;
    else if (issueLeft && holdFetch)  pendRight <= 1'b1;
    else if (pairValid && !holdFetch) pendRight <= 1'b0;
  end

  p_right_follows_left_r3: assert property (@(posedge clk) disable iff (!rstN)
    (issueRight && !issueLeft) |-> pendRight);

  p_intra_fp_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (issueLeft && li.isLoad && li.wrFp &&
     ((ri.rdFp1 && rSrc1 == lDst) || (ri.rdFp2 && rSrc2 == lDst))) |-> !issueRight);

  p_left_wrong_class_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && !pendRight && !li.legalLeft) |-> (squashSlot && !issueLeft && !issueRight));

  p_load_shadow_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(issueLeft && li.isLoad && li.wrInt) && li.rdInt1 && (lSrc1 == $past(lDst)))
      |-> !issueLeft);

  p_hold_excludes_finish_r8: assert property (@(posedge clk) disable iff (!rstN)
    holdFetch |-> (!issueRight && !squashSlot));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !pairValid |-> (!issueLeft && !issueRight && !holdFetch && !squashSlot));

endmodule

bind dual_issue_checker dual_issue_sva #(.NUM_REGS(NUM_REGS)) u_sva (.*);

// File: tb/dual_issue_checker_test.sv
module dual_issue_checker_test;

  localparam int CLK_PERIOD = 10;
  localparam int TB_REGS    = 8;
  localparam int TB_DELAY   = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pairValid = 1'b0;
  logic [63:0] pairWord = '0;
  logic        issueLeft;
  logic        issueRight;
  logic        holdFetch;
  logic        squashSlot;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit finished = 0;

  // Reference state: load-delay countdowns and the half-issued flag.
  int sbI [TB_REGS];
  int sbF [TB_REGS];
  bit mDone;

  dual_issue_checker #(.NUM_REGS(TB_REGS), .LOAD_DELAY(TB_DELAY)) uut (
    .clk(clk), .rstN(rstN), .pairValid(pairValid), .pairWord(pairWord),
    .issueLeft(issueLeft), .issueRight(issueRight),
    .holdFetch(holdFetch), .squashSlot(squashSlot)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [31:0] mk(input int cls, input int d, input int s1, input int s2);
    logic [31:0] w;
    w = '0;
    w[31:28] = 4'(cls);
    w[25:23] = 3'(d);
    w[20:18] = 3'(s1);
    w[15:13] = 3'(s2);
    return w;
  endfunction

  task automatic cmp(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < TB_REGS; i++) begin
      sbI[i] = 0;
      sbF[i] = 0;
    end
    mDone = 0;
  endtask

  // One cycle: drive, compare against expectations from the requirements,
  // advance the reference state.
  task automatic step(input bit pv, input logic [63:0] w, input string note, output bit ret);
    int lc, rc, ld, ls1, ls2, rs1, rs2;
    bit lLegal, rLegal, lBlk, rBlk, intra, eL, lSq, rEv, rSq, eR, eH, eS;
    string tag;
    @(negedge clk);
    pairValid = pv;
    pairWord  = w;
    #1;
    lc  = int'(w[63:60]);
    rc  = int'(w[31:28]);
    ld  = int'(w[57:55]);
    ls1 = int'(w[52:50]);
    ls2 = int'(w[47:45]);
    rs1 = int'(w[20:18]);
    rs2 = int'(w[15:13]);
    lLegal = (lc <= 4);
    rLegal = (rc == 0) || (rc == 5);
    lBlk = ((lc >= 1 && lc <= 4) && sbI[ls1] > 0) ||
           (lc == 1 && sbI[ls2] > 0) ||
           (lc == 4 && sbF[ls2] > 0);
    rBlk  = (rc == 5) && (sbF[rs1] > 0 || sbF[rs2] > 0);
    intra = (lc == 3) && (rc == 5) && (rs1 == ld || rs2 == ld);
    eL  = pv && !mDone && lLegal && !lBlk;
    lSq = pv && !mDone && !lLegal;
    rEv = pv && (eL || mDone);
    rSq = rEv && !rLegal;
    eR  = rEv && rLegal && !rBlk && !(eL && intra);
    ret = lSq || rSq || eR;
    eH  = pv && !ret;
    eS  = lSq || rSq;

    if (!pv)                tag = "R9 idle";
    else if (eS)            tag = "R5 wrong class";
    else if (mDone)         tag = "R7 held right";
    else if (eL && intra)   tag = "R4 in-pair load";
    else if (lBlk || rBlk)  tag = "R6 load shadow";
    else                    tag = "R2 pair";
    tag = {tag, " [", note, "]"};

    cmp(tag, "issueLeft", issueLeft, eL);
    cmp({tag, " R3"}, "issueRight", issueRight, eR);
    cmp({tag, " R8"}, "holdFetch", holdFetch, eH);
    cmp(tag, "squashSlot", squashSlot, eS);

    for (int i = 0; i < TB_REGS; i++) begin
      if (sbI[i] > 0) sbI[i]--;
      if (sbF[i] > 0) sbF[i]--;
    end
    if (eL && lc == 2) sbI[ld] = TB_DELAY;
    if (eL && lc == 3) sbF[ld] = TB_DELAY;
    if (ret)     mDone = 0;
    else if (eL) mDone = 1;
  endtask

  task automatic present(input string note, input logic [63:0] w);
    bit ret;
    ret = 0;
    for (int k = 0; k < 10 && !ret; k++) step(1'b1, w, note, ret);
    checks++;
    if (!ret) begin
      failures++;
      $display("FAIL R8 pair never completed [%s] actual=held expected=done", note);
    end
  endtask

  task automatic idle(input string note);
    bit ret;
    step(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, note, ret);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN      = 1'b0;
    pairValid = 1'b1;
    pairWord  = {mk(1, 1, 2, 3), mk(5, 1, 2, 3)};
    modelClear();
    @(negedge clk);
    #1;
    cmp("R10 in reset", "issueLeft", issueLeft, 1'b0);
    cmp("R10 in reset", "issueRight", issueRight, 1'b0);
    cmp("R10 in reset", "holdFetch", holdFetch, 1'b0);
    cmp("R10 in reset", "squashSlot", squashSlot, 1'b0);
    @(negedge clk);
    rstN      = 1'b1;
    pairValid = 1'b0;
  endtask

  initial begin
    modelClear();
    doReset();

    // R1 / R2: FP load beside an independent FP op issues as a pair.
    present("R1 fp load with fp op", {mk(3, 3, 1, 0), mk(5, 6, 4, 5)});
    idle("R9 gap");
    idle("R9 gap");
    // R4 then R7: the FP op reads the load's destination.
    present("R4 same-pair fp hazard", {mk(3, 2, 1, 0), mk(5, 7, 2, 4)});
    // R6: integer load, then a consumer in the next pair.
    present("R6 producer", {mk(2, 4, 0, 0), mk(0, 0, 0, 0)});
    present("R6 consumer", {mk(1, 5, 4, 1), mk(0, 0, 0, 0)});
    // R6: FP store data register under a load shadow.
    present("R6 fp producer", {mk(3, 6, 0, 0), mk(0, 0, 0, 0)});
    present("R6 fp store", {mk(4, 0, 1, 6), mk(5, 1, 2, 3)});
    // R5: wrong class in either slot.
    present("R5 left fp op", {mk(5, 1, 1, 1), mk(5, 2, 2, 2)});
    present("R5 right int op", {mk(1, 1, 2, 3), mk(1, 2, 2, 2)});
    present("R5 undefined class", {mk(15, 0, 0, 0), mk(0, 0, 0, 0)});
    // R10: reset clears an open load shadow.
    present("R10 producer", {mk(2, 6, 0, 0), mk(0, 0, 0, 0)});
    doReset();
    present("R10 consumer after reset", {mk(1, 1, 6, 6), mk(0, 0, 0, 0)});

    // Sweep every class pairing with arithmetic register fields.
    for (int lc = 0; lc < 16; lc++) begin
      for (int rc = 0; rc < 16; rc++) begin
        int ldst, rs1;
        ldst = (lc * 3 + rc) % 8;
        rs1  = ((lc + rc) % 2 == 0) ? ldst : (lc + 2) % 8;
        present("sweep",
                {mk(lc, ldst, (lc + rc * 5) % 8, (rc + 1) % 8),
                 mk(rc, (rc * 7) % 8, rs1, (lc * rc) % 8)});
        if ((lc + rc) % 3 == 0) idle("R9 sweep gap");
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule